// File: doc/BRIEF.md
# Fan Speed PWM Generator

This block drives a cooling fan through one pulse-width-modulated output pin. A 6-bit duty code sets the high time in steps of 1/64 of a period. Three selection bits pick the PWM rate from eight choices. One bit picks a kilohertz or a hertz range. A second bit picks the lower or the higher rate in that range. A third bit doubles the rate. A separate override bit holds the pin fully on.

A prescaler divides the system clock into a tick enable that runs at 64 times the chosen PWM rate. A 6-bit phase counter advances on each tick, and the pin is high while the phase is below the duty code. All settings are sampled together at the moment the phase wraps to zero. A mid-period change therefore never cuts a pulse short and never adds an extra edge. The divide ratios are parameters. By default they come from the system clock frequency, and each must be a multiple of 6.

Top module: `fan_pwm_gen`

## Requirements
- R1: With `forceOn` low and `dutyCode` equal to 0, `fanOut` stays low and never toggles.
- R2: With `forceOn` low and `dutyCode` D from 1 to 63, `fanOut` is high for D ticks and low for 64-D ticks of every period. That is D*div and (64-D)*div clock cycles.
- R3: With `forceOn` high, `fanOut` stays high, whatever the duty code and rate bits are.
- R4: Each PWM period is 64 ticks. The tick divisor `div` is chosen by {`srcSlow`,`rateAlt`} as follows. 00 gives FAST_DIV, for a 15.625 kHz PWM at the default clock. 01 gives FAST_DIV*2/3, for 23.4375 kHz. 10 gives SLOW_DIV, for 40 Hz. 11 gives SLOW_DIV*2/3, for 60 Hz. These divisors apply when `rateDouble` is 0.
- R5: With `rateDouble` at 1, every divisor in R4 is halved. The four rates double to 31.25 kHz, 46.875 kHz, 80 Hz and 120 Hz.
- R6: While reset is asserted, and after it is released, `fanOut` is low. It stays low until a non-zero duty or `forceOn` has been taken up at a period boundary.
- R7: The inputs are taken up only when the phase wraps from 63 to 0. A change made inside a period leaves that period's high time untouched, and every rising edge of `fanOut` falls at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| forceOn | input | 1 | Hold the output fully high |
| dutyCode | input | 6 | High time in 1/64 steps; 0 means always low |
| srcSlow | input | 1 | 0 selects the kHz range, 1 selects the Hz range |
| rateAlt | input | 1 | Selects the higher rate (x1.5) within the range |
| rateDouble | input | 1 | Doubles the selected rate |
| fanOut | output | 1 | Fan drive pin |

## Verification
A prescaler that reloads at the wrong count shows up within one period as a wrong period length for that selection. The bench measures this from edge to edge for all eight selections. A wrong compare or a phase counter off by one changes the measured high time by a whole tick. Duty codes 1, 32 and 63 expose this at once. If the settings latch is used outside the wrap point, a truncated pulse appears in the same period as the change. The bench makes such a change mid-pulse and measures that exact pulse.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int PHASE_W = 6;

  typedef struct packed {
    logic                 tick;
    logic                 forceHigh;
    logic [PHASE_W-1:0]   duty;
  } fanStrobe_t;
endpackage

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int FAST_DIV = 96,
  parameter int SLOW_DIV = 37500
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               forceOn,
  input  logic [PHASE_W-1:0] dutyCode,
  input  logic               srcSlow,
  input  logic               rateAlt,
  input  logic               rateDouble,
  input  logic               lastPhase,
  output fanStrobe_t         strobe
);
  localparam int DIV_W = $clog2(SLOW_DIV + 1);

  logic [DIV_W-1:0]   divTab [8];
  logic [2:0]         actSel;
  logic [PHASE_W-1:0] actDuty;
  logic               actForce;
  logic [DIV_W-1:0]   preCnt;
  logic [DIV_W-1:0]   curDiv;
  logic               tick;
  logic               boundary;

  // selection index = {range, alternate, double}
  for (genvar g = 0; g < 8; g++) begin : gDiv
    localparam int BASE = (g & 4) ? SLOW_DIV : FAST_DIV;
    localparam int ALT  = (g & 2) ? (BASE * 2) / 3 : BASE;
    localparam int FIN  = (g & 1) ? ALT / 2 : ALT;
    assign divTab[g] = DIV_W'(FIN);
  end

  assign curDiv   = divTab[actSel];
  assign tick     = (preCnt == curDiv - DIV_W'(1));
  assign boundary = tick && lastPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel   <= '0;
      actDuty  <= '0;
      actForce <= 1'b0;
    end else if (boundary) begin
      actSel   <= {srcSlow, rateAlt, rateDouble};
      actDuty  <= dutyCode;
      actForce <= forceOn;
    end
  end

  assign strobe.tick      = tick;
  assign strobe.forceHigh = actForce;
  assign strobe.duty      = actDuty;

  AST_LATCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable({actSel, actDuty, actForce})); // R7
endmodule

// File: rtl/fan_pwm_datapath.sv
module fan_pwm_datapath
  import fan_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fanStrobe_t strobe,
  output logic       lastPhase,
  output logic       fanOut
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (strobe.tick) begin
      phase <= phase + PHASE_W'(1);
    end
  end

  assign lastPhase = (phase == {PHASE_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fanOut <= 1'b0;
    end else begin
      fanOut <= strobe.forceHigh || (phase < strobe.duty);
    end
  end

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceHigh |=> fanOut); // R3
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.forceHigh && strobe.duty == '0) |=> !fanOut); // R1
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fanOut) |-> ($past(phase) == '0)); // R7
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int CLK_HZ   = 96_000_000,
  parameter int FAST_DIV = CLK_HZ / 1_000_000,
  parameter int SLOW_DIV = CLK_HZ / 2560
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       forceOn,
  input  logic [5:0] dutyCode,
  input  logic       srcSlow,
  input  logic       rateAlt,
  input  logic       rateDouble,
  output logic       fanOut
);
  fanStrobe_t strobe;
  logic       lastPhase;

  fan_pwm_ctrl #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .forceOn(forceOn), .dutyCode(dutyCode),
    .srcSlow(srcSlow), .rateAlt(rateAlt), .rateDouble(rateDouble),
    .lastPhase(lastPhase), .strobe(strobe)
  );

  fan_pwm_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lastPhase(lastPhase), .fanOut(fanOut)
  );
endmodule

// File: tb/tb_fan_pwm_gen.sv
module tb_fan_pwm_gen;
  localparam int FAST = 6;
  localparam int SLOW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic forceOn = 1'b0;
  logic [5:0] dutyCode = '0;
  logic srcSlow = 1'b0, rateAlt = 1'b0, rateDouble = 1'b0;
  logic fanOut;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fan_pwm_gen #(.FAST_DIV(FAST), .SLOW_DIV(SLOW)) dut (
    .clk(clk), .rstN(rstN), .forceOn(forceOn), .dutyCode(dutyCode),
    .srcSlow(srcSlow), .rateAlt(rateAlt), .rateDouble(rateDouble),
    .fanOut(fanOut)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expDiv(input bit s, input bit a, input bit d);
    int v = s ? SLOW : FAST;
    if (a) v = v * 2 / 3;
    if (d) v = v / 2;
    return v;
  endfunction

  task automatic waitFor(input logic val, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (fanOut === val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(output int hi, output int per);
    bit ok;
    int lo;
    hi = 0; lo = 0;
    waitFor(1'b0, ok);
    waitFor(1'b1, ok);
    if (!ok) begin per = -1; return; end
    while (fanOut === 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
    while (fanOut === 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic apply(input bit f, input int d, input bit s, input bit a, input bit m);
    @(negedge clk);
    forceOn = f; dutyCode = 6'(d); srcSlow = s; rateAlt = a; rateDouble = m;
  endtask

  task automatic testReset();
    int highs = 0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 during reset", int'(fanOut), 0);
    rstN = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (fanOut !== 1'b0) highs++;
    end
    check("R6 after reset", highs, 0);
  endtask

  task automatic testRate(input bit s, input bit a, input bit m, input int d, input string req);
    int hi, per, dv;
    dv = expDiv(s, a, m);
    apply(1'b0, d, s, a, m);
    measure(hi, per);
    measure(hi, per);
    check({req, " period"}, per, 64 * dv);
    check({"R2 high time ", req}, hi, d * dv);
  endtask

  task automatic testZero();
    int highs = 0;
    apply(1'b0, 0, 1'b0, 1'b0, 1'b0);
    repeat (2000) @(negedge clk);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (fanOut !== 1'b0) highs++;
    end
    check("R1 duty zero stays low", highs, 0);
  endtask

  task automatic testForce(input int d, input bit s);
    int lows = 0;
    apply(1'b1, d, s, 1'b1, 1'b0);
    repeat (2000) @(negedge clk);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (fanOut !== 1'b1) lows++;
    end
    check("R3 forced high", lows, 0);
  endtask

  task automatic testMidChange();
    int hi, per;
    bit ok;
    apply(1'b0, 32, 1'b0, 1'b0, 1'b0);
    measure(hi, per);
    waitFor(1'b0, ok);
    waitFor(1'b1, ok);
    hi = 0;
    while (fanOut === 1'b1 && hi < 4000) begin
      hi++;
      if (hi == 3) dutyCode = 6'd1;
      @(negedge clk);
    end
    check("R7 pulse kept after mid-period change", hi, 32 * FAST);
    measure(hi, per);
    check("R7 new duty at next period", hi, 1 * FAST);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    testReset();
    testRate(1'b0, 1'b0, 1'b0, 32, "R4 kHz low");
    testRate(1'b0, 1'b1, 1'b0, 32, "R4 kHz alt");
    testRate(1'b1, 1'b0, 1'b0, 32, "R4 Hz low");
    testRate(1'b1, 1'b1, 1'b0, 32, "R4 Hz alt");
    testRate(1'b0, 1'b0, 1'b1, 32, "R5 kHz low x2");
    testRate(1'b0, 1'b1, 1'b1, 32, "R5 kHz alt x2");
    testRate(1'b1, 1'b0, 1'b1, 32, "R5 Hz low x2");
    testRate(1'b1, 1'b1, 1'b1, 32, "R5 Hz alt x2");
    testRate(1'b0, 1'b0, 1'b0, 1, "R2 duty one");
    testRate(1'b1, 1'b0, 1'b0, 63, "R2 duty max");
    testRate(1'b0, 1'b1, 1'b1, 63, "R2 duty max fast");
    testZero();
    testForce(0, 1'b0);
    testForce(17, 1'b1);
    testMidChange();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule